// File: doc/BRIEF.md
# Parallel Flash Identity Probe

This block identifies a byte-wide parallel NOR flash device. After one pulse on `start` it watches the device's base location until the device has finished whatever program or erase it might have been running. It then puts the device into its identification mode, reads the vendor and device bytes, and returns the device to normal array reads. The outcome goes back to the host as a one-cycle `done` pulse, a pass/fail flag and the 16-bit identity.

The flash side is a single-outstanding request/acknowledge bus. A request is `fl_we` or `fl_re` held high together with `fl_addr` (and `fl_wdata` for writes). The request stays asserted and unchanged until the cycle in which `fl_ack` is sampled high. Read data on `fl_rdata` is taken in that same acknowledge cycle. The responder controls back-pressure by delaying `fl_ack` for as long as it needs. The requester never withdraws or changes a pending request. The host side is plain control: it has no back-pressure, and while a probe is running, `start` has no effect.

Top module: `flash_id_probe`

## Requirements
- R1: Settle wait. After `start`, the block reads offset 0 repeatedly. It stops once a read returns the same byte as the read just before it. If the device yields T mismatching neighbour pairs and then a match (T < SETTLE_MAX), there are exactly T+2 settle reads.
- R2: Settle timeout. After SETTLE_MAX compare reads that all mismatch (1+SETTLE_MAX settle reads in total), the block stops waiting and still runs the full identification sequence.
- R3: Once settled, exactly seven accesses follow, in this order: write 0xF0 to 0x555, write 0xAA to 0x555, write 0x55 to 0x2AA, write 0x90 to 0x555, read offset 0x000, read offset 0x001, write 0xF0 to 0x555.
- R4: `id` equals {byte read at offset 0, byte read at offset 1}. The vendor byte is in bits 15:8 and the device byte in bits 7:0. It is valid in the cycle `done` is high.
- R5: `ok` is 1 when both identity bytes have an odd number of set bits, and 0 when either byte has an even count (zero included).
- R6: The closing 0xF0 write to 0x555 is issued on the failing path as well as on the passing path.
- R7: `done` is high for exactly one cycle per accepted start. No bus request follows it until the next start.
- R8: A `start` pulse while a probe is running has no effect. It adds no access and no extra `done`.
- R9: `id` and `ok` change only in a cycle where `done` is high. They hold their previous values while a later probe runs.
- R10: `fl_we` and `fl_re` are never both high. A pending request keeps its address, data and kind until acknowledged, and is dropped in the cycle after the acknowledge.
- R11: During and after reset, `done`, `ok`, `id`, `fl_we` and `fl_re` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Both identity bytes had odd parity |
| id | output | 16 | Vendor byte (15:8) and device byte (7:0) |
| fl_addr | output | ADDR_W | Flash address of the pending access |
| fl_wdata | output | 8 | Write byte |
| fl_we | output | 1 | Write request |
| fl_re | output | 1 | Read request |
| fl_rdata | input | 8 | Read byte, taken when acknowledged |
| fl_ack | input | 1 | Access acknowledge |

## Verification
With a responder that acknowledges L cycles after it sees a request, each access occupies L+3 cycles from issue to the next issue. `done`, `id` and `ok` appear two cycles after the acknowledge of the closing reset write. The bench therefore never samples on a fixed cycle count. It polls on the falling edge until `done` is high, reads `id` and `ok` in that same sample, and checks that `done` is low one falling edge later. The access order and the settle-read counts are logged by the responder at each acknowledge and compared once the probe has finished. Stability of the old identity is checked at the first logged command write of the next probe.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  localparam int DATA_W = 8;
  localparam int OFF_W  = 11;
  localparam int SEQ_LEN = 7;
  localparam int STEP_W = $clog2(SEQ_LEN);

  localparam logic [DATA_W-1:0] CMD_RESET   = 8'hF0;
  localparam logic [DATA_W-1:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [DATA_W-1:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [DATA_W-1:0] CMD_IDENT   = 8'h90;
  localparam logic [OFF_W-1:0]  OFF_CMD_A   = 11'h555;
  localparam logic [OFF_W-1:0]  OFF_CMD_B   = 11'h2AA;

  // step positions the sequencer decodes
  localparam logic [STEP_W-1:0] STEP_VENDOR = STEP_W'(4);
  localparam logic [STEP_W-1:0] STEP_DEVICE = STEP_W'(5);
  localparam logic [STEP_W-1:0] STEP_LAST   = STEP_W'(SEQ_LEN - 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE_FIRST,
    PH_SETTLE_CMP,
    PH_SEQ
  } phase_e;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] data;
  } bus_op_t;

  localparam bus_op_t OP_BASE_READ = '{kind: OP_RD, off: '0, data: '0};

  // identification sequence: order is behaviour
  function automatic bus_op_t seq_op(input logic [STEP_W-1:0] idx);
    bus_op_t o;
    case (idx)
      3'd0:    o = '{kind: OP_WR, off: OFF_CMD_A, data: CMD_RESET};
      3'd1:    o = '{kind: OP_WR, off: OFF_CMD_A, data: CMD_UNLOCK1};
      3'd2:    o = '{kind: OP_WR, off: OFF_CMD_B, data: CMD_UNLOCK2};
      3'd3:    o = '{kind: OP_WR, off: OFF_CMD_A, data: CMD_IDENT};
      3'd4:    o = '{kind: OP_RD, off: 11'h000,   data: '0};
      3'd5:    o = '{kind: OP_RD, off: 11'h001,   data: '0};
      default: o = '{kind: OP_WR, off: OFF_CMD_A, data: CMD_RESET};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/fpe_bus_port.sv
module fpe_bus_port
  import fpe_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int unsigned BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  bus_op_t           op,
  output logic              op_done,
  output logic [DATA_W-1:0] op_rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              fl_ack
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic req;
  assign req = fl_we | fl_re;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
      op_done  <= 1'b0;
      op_rdata <= '0;
    end else begin
      op_done <= 1'b0;
      if (req && fl_ack) begin
        fl_we    <= 1'b0;
        fl_re    <= 1'b0;
        op_done  <= 1'b1;
        op_rdata <= fl_rdata;
      end else if (go && !req) begin
        fl_addr  <= BASE + ADDR_W'(op.off);
        fl_wdata <= op.data;
        fl_we    <= (op.kind == OP_WR);
        fl_re    <= (op.kind == OP_RD);
      end
    end
  end

endmodule

// File: rtl/fpe_settle.sv
module fpe_settle
  import fpe_pkg::*;
#(
  parameter int SETTLE_MAX = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample_vld,
  input  logic              first,
  input  logic [DATA_W-1:0] sample,
  output logic              finish
);

  localparam int CNT_W = $clog2(SETTLE_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_MAX - 1);

  logic [DATA_W-1:0] prev_q;
  logic [CNT_W-1:0]  miss_q;
  logic              match;

  assign match  = (sample == prev_q);
  assign finish = sample_vld && !first && (match || (miss_q == CNT_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      miss_q <= '0;
    end else if (clear) begin
      miss_q <= '0;
    end else if (sample_vld) begin
      prev_q <= sample;
      if (!first && !match) miss_q <= miss_q + 1'b1;
    end
  end

endmodule

// File: rtl/fpe_parity.sv
module fpe_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  output logic         odd
);
  assign odd = ^value;
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import fpe_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int unsigned BASE_ADDR  = 0,
  parameter int          SETTLE_MAX = 10000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                done,
  output logic                ok,
  output logic [2*DATA_W-1:0] id,
  output logic [ADDR_W-1:0]   fl_addr,
  output logic [DATA_W-1:0]   fl_wdata,
  output logic                fl_we,
  output logic                fl_re,
  input  logic [DATA_W-1:0]   fl_rdata,
  input  logic                fl_ack
);

  localparam int NBYTES = 2;

  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  logic [DATA_W-1:0] vendor_q, device_q;

  logic              go;
  bus_op_t           op;
  logic              op_done;
  logic [DATA_W-1:0] op_rdata;
  logic              settle_vld, settle_first, settle_finish;
  logic [NBYTES-1:0] odd_vec;
  logic [DATA_W-1:0] id_bytes [NBYTES];

  assign settle_first = (phase_q == PH_SETTLE_FIRST);
  assign settle_vld   = op_done && (settle_first || phase_q == PH_SETTLE_CMP);

  always_comb begin
    go = 1'b0;
    op = OP_BASE_READ;
    unique case (phase_q)
      PH_IDLE: go = start;
      PH_SETTLE_FIRST: go = op_done;
      PH_SETTLE_CMP: begin
        go = op_done;
        if (settle_finish) op = seq_op('0);
      end
      PH_SEQ: begin
        go = op_done && (step_q != STEP_LAST);
        op = seq_op(step_q + 1'b1);
      end
      default: go = 1'b0;
    endcase
  end

  fpe_bus_port #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .op       (op),
    .op_done  (op_done),
    .op_rdata (op_rdata),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_we    (fl_we),
    .fl_re    (fl_re),
    .fl_rdata (fl_rdata),
    .fl_ack   (fl_ack)
  );

  fpe_settle #(.SETTLE_MAX(SETTLE_MAX)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (phase_q == PH_IDLE),
    .sample_vld (settle_vld),
    .first      (settle_first),
    .sample     (op_rdata),
    .finish     (settle_finish)
  );

  assign id_bytes[0] = device_q;
  assign id_bytes[1] = vendor_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_par
    fpe_parity #(.W(DATA_W)) u_par (
      .value (id_bytes[g]),
      .odd   (odd_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      step_q   <= '0;
      vendor_q <= '0;
      device_q <= '0;
      done     <= 1'b0;
      ok       <= 1'b0;
      id       <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start) phase_q <= PH_SETTLE_FIRST;
        PH_SETTLE_FIRST: if (op_done) phase_q <= PH_SETTLE_CMP;
        PH_SETTLE_CMP: if (op_done && settle_finish) begin
          phase_q <= PH_SEQ;
          step_q  <= '0;
        end
        PH_SEQ: if (op_done) begin
          if (step_q == STEP_VENDOR) vendor_q <= op_rdata;
          if (step_q == STEP_DEVICE) device_q <= op_rdata;
          if (step_q == STEP_LAST) begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
            ok      <= &odd_vec;
            id      <= {vendor_q, device_q};
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpe_probe_checker.sv
module fpe_probe_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              ok,
  input logic [15:0]       id,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [7:0]        fl_wdata,
  input logic              fl_we,
  input logic              fl_re,
  input logic              fl_ack
);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_we || fl_re) && !fl_ack) |=>
      ($stable(fl_addr) && $stable(fl_wdata) && $stable(fl_we) && $stable(fl_re)));

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_we || fl_re) && fl_ack) |=> !(fl_we || fl_re));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(fl_we || fl_re));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(id) && $stable(ok)));

endmodule

bind flash_id_probe fpe_probe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .ok       (ok),
  .id       (id),
  .fl_addr  (fl_addr),
  .fl_wdata (fl_wdata),
  .fl_we    (fl_we),
  .fl_re    (fl_re),
  .fl_ack   (fl_ack)
);

// File: tb/flash_id_probe_tb_top.sv
`timescale 1ns/1ps
module flash_id_probe_tb_top;

  localparam int ADDR_W = 20;
  localparam int SETTLE = 10000;
  localparam int NVEC   = 7;
  localparam int LOGSZ  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, ok;
  logic [15:0] id;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re, fl_ack;

  always #2 clk = ~clk;

  flash_id_probe #(.ADDR_W(ADDR_W), .BASE_ADDR(0), .SETTLE_MAX(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .ok(ok), .id(id),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .fl_ack(fl_ack)
  );

  int checks = 0;
  int failures = 0;

  // responder configuration (driven only by the stimulus process)
  int lat_cfg = 0;
  int tog_cfg = 0;
  int settle_base = 0;
  logic [7:0] vend_cfg = 8'h00;
  logic [7:0] dev_cfg = 8'h00;

  // responder state (driven only by the model process)
  int  wait_cnt = 0;
  bit  ident_mode = 1'b0;
  int  settle_rd = 0;
  int  op_n = 0;
  int  done_cnt = 0;
  int  proto_err = 0;
  bit  log_wr [LOGSZ];
  logic [ADDR_W-1:0] log_addr [LOGSZ];
  logic [7:0] log_data [LOGSZ];
  logic [ADDR_W-1:0] pend_addr;
  bit  pending = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      fl_ack <= 1'b0;
      fl_rdata <= 8'h00;
      wait_cnt <= 0;
      ident_mode <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (done) done_cnt <= done_cnt + 1;
      if (fl_we && fl_re) proto_err <= proto_err + 1;
      if ((fl_we || fl_re) && !fl_ack) begin
        if (pending && pend_addr != fl_addr) proto_err <= proto_err + 1;
        pending <= 1'b1;
        pend_addr <= fl_addr;
        if (wait_cnt >= lat_cfg) begin
          fl_ack <= 1'b1;
          wait_cnt <= 0;
          pending <= 1'b0;
          if (fl_we) begin
            if (fl_addr == 'h555 && fl_wdata == 8'h90) ident_mode <= 1'b1;
            if (fl_wdata == 8'hF0) ident_mode <= 1'b0;
            if (op_n < LOGSZ) begin
              log_wr[op_n] <= 1'b1; log_addr[op_n] <= fl_addr; log_data[op_n] <= fl_wdata;
            end
            op_n <= op_n + 1;
          end else if (!ident_mode) begin
            fl_rdata <= ((settle_rd - settle_base) < tog_cfg) ?
                        8'(settle_rd - settle_base) : 8'(tog_cfg);
            settle_rd <= settle_rd + 1;
          end else begin
            fl_rdata <= (fl_addr == 0) ? vend_cfg : ((fl_addr == 1) ? dev_cfg : 8'h00);
            if (op_n < LOGSZ) begin
              log_wr[op_n] <= 1'b0; log_addr[op_n] <= fl_addr; log_data[op_n] <= 8'h00;
            end
            op_n <= op_n + 1;
          end
        end else begin
          wait_cnt <= wait_cnt + 1;
        end
      end else begin
        fl_ack <= 1'b0;
      end
    end
  end

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected access i of the identification sequence: {wr, addr, data}
  function automatic logic [28:0] exp_op(input int i);
    case (i)
      0: return {1'b1, 20'h555, 8'hF0};
      1: return {1'b1, 20'h555, 8'hAA};
      2: return {1'b1, 20'h2AA, 8'h55};
      3: return {1'b1, 20'h555, 8'h90};
      4: return {1'b0, 20'h000, 8'h00};
      5: return {1'b0, 20'h001, 8'h00};
      default: return {1'b1, 20'h555, 8'hF0};
    endcase
  endfunction

  // {vendor, device, toggles, latency, expected ok}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h01, 8'hAD, 16'd0, 4'd0, 4'd1},
    {8'hC2, 8'hAD, 16'd3, 4'd1, 4'd1},
    {8'h20, 8'hE3, 16'd5, 4'd2, 4'd1},
    {8'h03, 8'hAD, 16'd1, 4'd0, 4'd0},
    {8'h01, 8'h00, 16'd2, 4'd1, 4'd0},
    {8'h11, 8'h22, 16'd0, 4'd0, 4'd0},
    {8'h80, 8'h01, 16'd0, 4'd2, 4'd1}
  };

  task automatic run_probe(input logic [7:0] v, input logic [7:0] d, input int tog,
                           input int lat, input bit exp_ok, input bit extra_start);
    int op0, dn0, sr0, exp_settle, guard;
    logic [15:0] old_id;
    logic old_ok;
    bit seen;
    @(negedge clk);
    vend_cfg = v; dev_cfg = d; tog_cfg = tog; lat_cfg = lat;
    settle_base = settle_rd;
    op0 = op_n; dn0 = done_cnt; sr0 = settle_rd;
    old_id = id; old_ok = ok;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (op_n == op0 && guard < 80000) begin @(negedge clk); guard++; end
    check(id == old_id && ok == old_ok, "R9", "result held during next probe",
          {15'd0, ok, id}, {15'd0, old_ok, old_id});
    seen = 1'b0;
    while (!seen && guard < 80000) begin
      if (done) seen = 1'b1; else begin @(negedge clk); guard++; end
    end
    check(seen, "R7", "done seen", 32'(seen), 32'd1);
    check(id == {v, d}, "R4", "identity", 32'(id), 32'({v, d}));
    check(ok == exp_ok, exp_ok ? "R5" : "R5_R6", "parity flag", 32'(ok), 32'(exp_ok));
    @(negedge clk);
    check(!done, "R7", "done one cycle", 32'(done), 32'd0);
    repeat (20) @(negedge clk);
    check(done_cnt - dn0 == 1, extra_start ? "R8" : "R7", "done count",
          32'(done_cnt - dn0), 32'd1);
    check(op_n - op0 == 7, "R3", "access count", 32'(op_n - op0), 32'd7);
    for (int i = 0; i < 7; i++) begin
      logic [28:0] got;
      got = {log_wr[op0 + i], log_addr[op0 + i], log_data[op0 + i]};
      check(got == exp_op(i), (i == 6 && !exp_ok) ? "R6" : "R3", "access order",
            32'(got), 32'(exp_op(i)));
    end
    exp_settle = (tog < SETTLE) ? tog + 2 : SETTLE + 1;
    check(settle_rd - sr0 == exp_settle, (tog < SETTLE) ? "R1" : "R2", "settle reads",
          32'(settle_rd - sr0), 32'(exp_settle));
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!done && !ok && id == 16'h0 && !fl_we && !fl_re, "R11", "state in reset",
          {27'd0, done, ok, fl_we, fl_re, |id}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !ok && id == 16'h0 && !fl_we && !fl_re, "R11", "state after reset",
          {27'd0, done, ok, fl_we, fl_re, |id}, 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      logic [39:0] e;
      e = VEC[k];
      run_probe(e[39:32], e[31:24], int'(e[23:8]), int'(e[7:4]), e[0], 1'b0);
    end

    // busy start ignored
    run_probe(8'h01, 8'hD5, 6, 1, 1'b1, 1'b1);
    // settle boundary: last allowed compare read matches
    run_probe(8'h01, 8'hA4, SETTLE - 1, 0, 1'b1, 1'b0);
    // settle timeout: every compare read mismatches
    run_probe(8'h20, 8'hE3, SETTLE, 0, 1'b1, 1'b0);

    check(proto_err == 0, "R10", "request exclusivity and hold", 32'(proto_err), 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule